// File: doc/BRIEF.md
# Parallel Camera Single-Frame Capture

This block takes pixels from a parallel camera port and stores exactly one frame in memory. The camera supplies a frame-valid strobe, a line-valid strobe and a 16-bit data bus whose low 10 bits hold the pixel. The pixel clock is the block clock. A pixel is taken on each edge where both strobes are at their active level. No horizontal offset applies, so the first pixel of a line is the first edge on which line-valid is active. Each strobe has its own polarity setting.

Software arms the block with a start pulse. The block then waits for the next frame-valid assertion, so a frame that is already running is passed over. It then captures a fixed number of lines of fixed width, stops, and raises a sticky done flag. An interrupt line follows that flag when the enable is set. Pixels are stored either as zero-extended halfwords or as 8-bit values taken from the top eight pixel bits. They are packed into 32-byte bursts, and each burst leaves on a one-cycle write strobe with its address. Lines are placed one stride apart. The stride is the line size in bytes rounded up to a multiple of 32. Optional byte, halfword and word swaps reorder each burst before it leaves.

Top module: `camFrameCapture`

## Requirements
- R1: During and straight after reset, wrValid, busy, frameDone, paramErr and irq are all 0.
- R2: A pixel is taken only on a clock edge where both frame-valid and line-valid are at their active levels. Data seen on any other edge, including line-valid pulses while frame-valid is inactive, never reaches memory.
- R3: cfgVdLow and cfgHdLow choose the active level of their strobes: 0 means active-high and 1 means active-low.
- R4: With cfgPack8=0, pixel k of a burst sits at bytes 2k (low) and 2k+1 (high) as {6'b0, camData[9:0]}. With cfgPack8=1, pixel k is byte k and holds camData[9:2]. Bits [15:10] are ignored.
- R5: A burst holds 32 bytes, with byte j at wrData[8j+7:8j]. wrValid pulses for one cycle, right after the clock edge that takes the burst's last pixel. The last burst of a line is sent at the line's final pixel, and its unused bytes are zero.
- R6: wrAddr equals base + line*stride + burst*32. The stride is LINE_PIX*bytesPerPixel rounded up to a multiple of 32, and the base is latched at arm.
- R7: A start pulse while idle with an aligned base arms the block, and busy rises. Capture begins at the first inactive-to-active change of frame-valid after the arm. After LINE_CNT lines of LINE_PIX pixels, busy falls and frameDone is set. Camera activity while idle writes nothing.
- R8: irq is 1 exactly when frameDone is 1 and cfgIntEn is 1.
- R9: A start pulse with cfgBaseAddr[1:0] nonzero sets paramErr, leaves the block idle and leaves frameDone unchanged. A valid start clears both paramErr and frameDone.
- R10: In the sent burst, output byte j holds packed byte j XOR (cfgSwapByte?1:0) XOR (cfgSwapHalf?2:0) XOR (cfgSwapWord?4:0). In effect this swaps bytes within halfwords, halfwords within words, and words within 8-byte units.
- R11: A start pulse while busy has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startCmd | input | 1 | One-cycle arm request |
| cfgBaseAddr | input | 32 | Buffer base byte address, must be 4-byte aligned |
| cfgVdLow | input | 1 | Frame-valid active-low when 1 |
| cfgHdLow | input | 1 | Line-valid active-low when 1 |
| cfgPack8 | input | 1 | Store 8-bit pixels when 1, halfwords when 0 |
| cfgSwapByte | input | 1 | Swap bytes within halfwords |
| cfgSwapHalf | input | 1 | Swap halfwords within words |
| cfgSwapWord | input | 1 | Swap words within 8-byte units |
| cfgIntEn | input | 1 | Frame-done interrupt enable |
| camVd | input | 1 | Frame-valid strobe |
| camHd | input | 1 | Line-valid strobe |
| camData | input | 16 | Camera data bus, pixel in bits [9:0] |
| wrValid | output | 1 | Burst write strobe |
| wrAddr | output | 32 | Burst byte address |
| wrData | output | 256 | Burst data |
| busy | output | 1 | Armed or capturing |
| frameDone | output | 1 | Sticky frame-complete flag |
| paramErr | output | 1 | Last start rejected for a misaligned base |
| irq | output | 1 | Frame-done interrupt |

## Verification
The assertions assume that the base address and the mode and swap settings stay fixed from the start pulse to the end of the frame. They also assume that the camera sends exactly LINE_PIX active pixels in each line-valid pulse, since line ends are found by counting. The stimulus changes configuration only while the block is idle, and always with both strobes inactive under the new polarity, so no false frame start appears. Every line is driven at full width with blank cycles in between. Stray strobe activity comes only as line-valid pulses outside frame-valid, as a frame already in progress at arm time, or as traffic after the frame is done.

// File: rtl/camCapPkg.sv
package camCapPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CAPT} capState_t;

  typedef struct packed {
    logic arm;       // clear packing state, latch base
    logic accept;    // a pixel is taken this edge
    logic lineLast;  // the accepted pixel closes its line
  } capStrobe_t;
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import camCapPkg::*;
#(
  parameter int LINE_PIX = 752,
  parameter int LINE_CNT = 480,
  localparam int PCW = $clog2(LINE_PIX + 1),
  localparam int LCW = $clog2(LINE_CNT + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           startCmd,
  input  logic           baseMisaligned,
  input  logic           camVd,
  input  logic           camHd,
  input  logic           vdLow,
  input  logic           hdLow,
  output capStrobe_t     strobe,
  output logic [LCW-1:0] lineIdx,
  output logic           busy,
  output logic           frameDone,
  output logic           paramErr
);
  capState_t state;
  logic [PCW-1:0] pixCnt;
  logic [LCW-1:0] lineCnt;
  logic vdPrev;
  logic vdAct, hdAct, vdRise, capturing, frameLast, armNow, rejectNow;

  assign vdAct     = camVd ^ vdLow;
  assign hdAct     = camHd ^ hdLow;
  assign vdRise    = vdAct & ~vdPrev;
  assign capturing = (state == ST_CAPT) || (state == ST_WAIT && vdRise);
  assign armNow    = startCmd && (state == ST_IDLE) && !baseMisaligned;
  assign rejectNow = startCmd && (state == ST_IDLE) && baseMisaligned;

  always_comb begin
    strobe.arm      = armNow;
    strobe.accept   = capturing && vdAct && hdAct;
    strobe.lineLast = strobe.accept && (pixCnt == PCW'(LINE_PIX - 1));
  end
  assign frameLast = strobe.lineLast && (lineCnt == LCW'(LINE_CNT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pixCnt    <= '0;
      lineCnt   <= '0;
      vdPrev    <= 1'b0;
      frameDone <= 1'b0;
      paramErr  <= 1'b0;
    end else begin
      vdPrev <= vdAct;
      if (armNow) begin
        state     <= ST_WAIT;
        pixCnt    <= '0;
        lineCnt   <= '0;
        frameDone <= 1'b0;
        paramErr  <= 1'b0;
      end else if (rejectNow) begin
        paramErr <= 1'b1;
      end else begin
        if (state == ST_WAIT && vdRise) state <= ST_CAPT;
        if (strobe.accept) begin
          if (strobe.lineLast) begin
            pixCnt  <= '0;
            lineCnt <= lineCnt + 1'b1;
          end else begin
            pixCnt <= pixCnt + 1'b1;
          end
        end
        if (frameLast) begin
          state     <= ST_IDLE;
          frameDone <= 1'b1;
        end
      end
    end
  end

  assign lineIdx = lineCnt;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import camCapPkg::*;
#(
  parameter int LINE_PIX    = 752,
  parameter int BURST_BYTES = 32,
  parameter int ADDR_W      = 32,
  parameter int IN_W        = 16,
  parameter int PIX_W       = 10,
  parameter int LCW         = 9,
  localparam int DW       = BURST_BYTES * 8,
  localparam int FW       = $clog2(BURST_BYTES),
  localparam int BW       = $clog2((2 * LINE_PIX) / BURST_BYTES + 2),
  localparam int STRIDE8  = ((LINE_PIX + BURST_BYTES - 1) / BURST_BYTES) * BURST_BYTES,
  localparam int STRIDE16 = ((2 * LINE_PIX + BURST_BYTES - 1) / BURST_BYTES) * BURST_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [LCW-1:0]    lineIdx,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              pack8,
  input  logic              swapByte,
  input  logic              swapHalf,
  input  logic              swapWord,
  input  logic [IN_W-1:0]   camData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DW-1:0]     wrData
);
  logic [DW-1:0]     packBuf, bufNext;
  logic [FW-1:0]     fill;
  logic [FW:0]       fillNext;
  logic [BW-1:0]     burstIdx;
  logic [ADDR_W-1:0] baseLat, addrNow, strideSel;
  logic [FW+3:0]     bitIdx;
  logic              burstFull;
  logic [DW-1:0]     stage1, stage2, stage3;
  logic              unusedHigh;

  assign unusedHigh = ^camData[IN_W-1:PIX_W];

  assign fillNext  = {1'b0, fill} + (pack8 ? (FW+1)'(1) : (FW+1)'(2));
  assign burstFull = (fillNext == (FW+1)'(BURST_BYTES));
  assign bitIdx    = {1'b0, fill, 3'b000};

  always_comb begin
    bufNext = packBuf;
    if (pack8) bufNext[bitIdx +: 8] = camData[PIX_W-1 -: 8];
    else       bufNext[bitIdx +: 16] = 16'(camData[PIX_W-1:0]);
  end

  assign strideSel = pack8 ? ADDR_W'(STRIDE8) : ADDR_W'(STRIDE16);
  assign addrNow   = baseLat + ADDR_W'(lineIdx) * strideSel
                   + ADDR_W'(burstIdx) * ADDR_W'(BURST_BYTES);

  // swap network: bytes in halfwords, halfwords in words, words in 8-byte units
  for (genvar h = 0; h < BURST_BYTES / 2; h++) begin : gSwapB
    assign stage1[h*16 +: 16] = swapByte ? {bufNext[h*16 +: 8], bufNext[h*16+8 +: 8]}
                                         : bufNext[h*16 +: 16];
  end
  for (genvar w = 0; w < BURST_BYTES / 4; w++) begin : gSwapH
    assign stage2[w*32 +: 32] = swapHalf ? {stage1[w*32 +: 16], stage1[w*32+16 +: 16]}
                                         : stage1[w*32 +: 32];
  end
  for (genvar d = 0; d < BURST_BYTES / 8; d++) begin : gSwapW
    assign stage3[d*64 +: 64] = swapWord ? {stage2[d*64 +: 32], stage2[d*64+32 +: 32]}
                                         : stage2[d*64 +: 64];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packBuf  <= '0;
      fill     <= '0;
      burstIdx <= '0;
      baseLat  <= '0;
      wrValid  <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrValid <= 1'b0;
      if (strobe.arm) begin
        packBuf  <= '0;
        fill     <= '0;
        burstIdx <= '0;
        baseLat  <= baseAddr;
      end else if (strobe.accept) begin
        if (burstFull || strobe.lineLast) begin
          wrValid  <= 1'b1;
          wrData   <= stage3;
          wrAddr   <= addrNow;
          packBuf  <= '0;
          fill     <= '0;
          burstIdx <= strobe.lineLast ? '0 : burstIdx + 1'b1;
        end else begin
          packBuf <= bufNext;
          fill    <= fillNext[FW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/camFrameCapture.sv
module camFrameCapture
  import camCapPkg::*;
#(
  parameter int LINE_PIX    = 752,
  parameter int LINE_CNT    = 480,
  parameter int BURST_BYTES = 32,
  parameter int ADDR_W      = 32,
  parameter int IN_W        = 16,
  parameter int PIX_W       = 10,
  localparam int DW  = BURST_BYTES * 8,
  localparam int LCW = $clog2(LINE_CNT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic [ADDR_W-1:0] cfgBaseAddr,
  input  logic              cfgVdLow,
  input  logic              cfgHdLow,
  input  logic              cfgPack8,
  input  logic              cfgSwapByte,
  input  logic              cfgSwapHalf,
  input  logic              cfgSwapWord,
  input  logic              cfgIntEn,
  input  logic              camVd,
  input  logic              camHd,
  input  logic [IN_W-1:0]   camData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DW-1:0]     wrData,
  output logic              busy,
  output logic              frameDone,
  output logic              paramErr,
  output logic              irq
);
  capStrobe_t     strobe;
  logic [LCW-1:0] lineIdx;

  capCtrl #(.LINE_PIX(LINE_PIX), .LINE_CNT(LINE_CNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd),
    .baseMisaligned(|cfgBaseAddr[1:0]),
    .camVd(camVd), .camHd(camHd), .vdLow(cfgVdLow), .hdLow(cfgHdLow),
    .strobe(strobe), .lineIdx(lineIdx), .busy(busy),
    .frameDone(frameDone), .paramErr(paramErr)
  );

  capDatapath #(.LINE_PIX(LINE_PIX), .BURST_BYTES(BURST_BYTES), .ADDR_W(ADDR_W),
                .IN_W(IN_W), .PIX_W(PIX_W), .LCW(LCW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIdx(lineIdx),
    .baseAddr(cfgBaseAddr), .pack8(cfgPack8), .swapByte(cfgSwapByte),
    .swapHalf(cfgSwapHalf), .swapWord(cfgSwapWord), .camData(camData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign irq = frameDone & cfgIntEn;
endmodule

// File: rtl/camFrameCapture_chk.sv
module camFrameCapture_chk #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic [ADDR_W-1:0] cfgBaseAddr,
  input logic              busy,
  input logic              frameDone,
  input logic              paramErr,
  input logic              irq,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr
);
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> frameDone); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !busy); // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |-> !busy); // R9
  AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (busy || $past(busy))); // R7
  AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr[1:0] == 2'b00)); // R6
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy && cfgBaseAddr[1:0] == 2'b00) |=> (busy && !frameDone && !paramErr)); // R7
  AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (startCmd && !busy && cfgBaseAddr[1:0] != 2'b00) |=> (paramErr && !busy)); // R9
endmodule

bind camFrameCapture camFrameCapture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .cfgBaseAddr(cfgBaseAddr),
  .busy(busy), .frameDone(frameDone), .paramErr(paramErr), .irq(irq),
  .wrValid(wrValid), .wrAddr(wrAddr)
);

// File: tb/camFrameCapture_tb.sv
module camFrameCapture_tb;
  localparam int LP = 20;
  localparam int LC = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, startCmd, cfgVdLow, cfgHdLow, cfgPack8, cfgSwapByte, cfgSwapHalf, cfgSwapWord, cfgIntEn;
  logic [31:0] cfgBaseAddr;
  logic camVd, camHd;
  logic [15:0] camData;
  logic wrValid, busy, frameDone, paramErr, irq;
  logic [31:0] wrAddr;
  logic [255:0] wrData;

  camFrameCapture #(.LINE_PIX(LP), .LINE_CNT(LC)) u_dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .cfgBaseAddr(cfgBaseAddr),
    .cfgVdLow(cfgVdLow), .cfgHdLow(cfgHdLow), .cfgPack8(cfgPack8),
    .cfgSwapByte(cfgSwapByte), .cfgSwapHalf(cfgSwapHalf), .cfgSwapWord(cfgSwapWord),
    .cfgIntEn(cfgIntEn), .camVd(camVd), .camHd(camHd), .camData(camData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .frameDone(frameDone), .paramErr(paramErr), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0]  recAddr [64];
  logic [255:0] recData [64];
  int nRec = 0;

  always @(negedge clk) begin
    if (wrValid && nRec < 64) begin
      recAddr[nRec] = wrAddr;
      recData[nRec] = wrData;
      nRec = nRec + 1;
    end
  end

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] pixVal(int seed, int line, int col);
    return 10'(seed * 37 + line * 53 + col * 11 + 5);
  endfunction

  function automatic logic [255:0] expBurst(int seed, int line, int b, bit p8, bit s8, bit s16, bit s32);
    logic [7:0] raw [32];
    logic [255:0] r;
    logic [9:0] v;
    int ppb;
    ppb = p8 ? 32 : 16;
    for (int j = 0; j < 32; j++) raw[j] = 8'h00;
    for (int i = 0; i < ppb; i++) begin
      if (b * ppb + i < LP) begin
        v = pixVal(seed, line, b * ppb + i);
        if (p8) raw[i] = v[9:2];
        else begin
          raw[2*i]   = v[7:0];
          raw[2*i+1] = {6'b0, v[9:8]};
        end
      end
    end
    for (int j = 0; j < 32; j++)
      r[j*8 +: 8] = raw[j ^ (s8 ? 1 : 0) ^ (s16 ? 2 : 0) ^ (s32 ? 4 : 0)];
    return r;
  endfunction

  task automatic setBus(bit vdA, bit hdA, logic [15:0] d);
    camVd   = vdA ^ cfgVdLow;
    camHd   = hdA ^ cfgHdLow;
    camData = d;
  endtask

  task automatic configure(bit p8, bit s8, bit s16, bit s32, bit vdl, bit hdl, logic [31:0] base, bit ie);
    @(negedge clk);
    cfgPack8 = p8; cfgSwapByte = s8; cfgSwapHalf = s16; cfgSwapWord = s32;
    cfgVdLow = vdl; cfgHdLow = hdl; cfgBaseAddr = base; cfgIntEn = ie;
    setBus(0, 0, 16'h0000);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); startCmd = 1'b1;
    @(negedge clk); startCmd = 1'b0;
  endtask

  task automatic driveFrame(int seed, bit timing, bit midStart);
    int ppb;
    ppb = cfgPack8 ? 32 : 16;
    for (int i = 0; i < 2; i++) begin @(negedge clk); setBus(0, 1, 16'hFFFF); end // R2 stray HD
    for (int i = 0; i < 2; i++) begin @(negedge clk); setBus(1, 0, 16'hABCD); end
    for (int line = 0; line < LC; line++) begin
      for (int col = 0; col < LP; col++) begin
        @(negedge clk);
        if (timing && line == 0 && col == ppb - 1) chk("R5", "no early burst", 256'(wrValid), 256'(0));
        if (timing && line == 0 && col == ppb)     chk("R5", "burst pulse after last pixel", 256'(wrValid), 256'(1));
        if (timing && line == 0 && col == ppb + 1) chk("R5", "pulse lasts one cycle", 256'(wrValid), 256'(0));
        startCmd = midStart && line == 1 && col == 0;
        setBus(1, 1, {6'b110101, pixVal(seed, line, col)});
      end
      for (int b = 0; b < 3; b++) begin @(negedge clk); startCmd = 1'b0; setBus(1, 0, 16'h03FF); end
    end
    for (int i = 0; i < 3; i++) begin @(negedge clk); setBus(0, 0, 16'h0000); end
  endtask

  task automatic checkFrame(string tag, int seed, logic [31:0] base);
    int bpl, idx;
    bit p8;
    p8  = cfgPack8;
    bpl = p8 ? (LP + 31) / 32 : (2 * LP + 31) / 32;
    chk(tag, "burst count", 256'(nRec), 256'(LC * bpl));
    for (int l = 0; l < LC; l++)
      for (int b = 0; b < bpl; b++) begin
        idx = l * bpl + b;
        if (idx < nRec) begin
          chk("R6", "burst address", 256'(recAddr[idx]), 256'(base + 32'(l * bpl * 32 + b * 32)));
          chk(tag, "burst data", recData[idx],
              expBurst(seed, l, b, p8, cfgSwapByte, cfgSwapHalf, cfgSwapWord));
        end
      end
  endtask

  task automatic testReset();
    rstN = 1'b0; startCmd = 1'b0;
    cfgPack8 = 0; cfgSwapByte = 0; cfgSwapHalf = 0; cfgSwapWord = 0;
    cfgVdLow = 0; cfgHdLow = 0; cfgBaseAddr = 32'h0; cfgIntEn = 1;
    setBus(0, 0, 16'h0);
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", 256'({wrValid, busy, frameDone, paramErr, irq}), 256'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs after reset", 256'({wrValid, busy, frameDone, paramErr, irq}), 256'(0));
  endtask

  task automatic testWide();
    configure(0, 0, 0, 0, 0, 0, 32'h0000_1000, 1);
    nRec = 0;
    pulseStart();
    chk("R7", "busy after arm", 256'(busy), 256'(1));
    driveFrame(1, 1, 0);
    checkFrame("R4", 1, 32'h0000_1000);
    chk("R7", "done flag", 256'({busy, frameDone}), 256'(2'b01));
    chk("R8", "irq enabled", 256'(irq), 256'(1));
  endtask

  task automatic testNarrowLow();
    configure(1, 1, 0, 1, 1, 1, 32'h0000_2004, 0);
    nRec = 0;
    pulseStart();
    driveFrame(2, 0, 0);
    checkFrame("R3", 2, 32'h0000_2004); // active-low strobes, 8-bit, R10 swaps
    chk("R8", "irq masked", 256'({frameDone, irq}), 256'(2'b10));
  endtask

  task automatic testWideSwap();
    configure(0, 1, 1, 1, 0, 1, 32'h0000_0040, 1);
    nRec = 0;
    pulseStart();
    driveFrame(3, 0, 0);
    checkFrame("R10", 3, 32'h0000_0040);
  endtask

  task automatic testSkipAndRestart();
    configure(0, 0, 0, 0, 0, 0, 32'h0000_8000, 1);
    nRec = 0;
    @(negedge clk); setBus(1, 0, 16'h0);
    @(negedge clk);
    pulseStart();
    for (int col = 0; col < LP; col++) begin @(negedge clk); setBus(1, 1, {6'b0, pixVal(9, 0, col)}); end
    @(negedge clk); setBus(1, 0, 16'h0);
    repeat (2) begin @(negedge clk); setBus(0, 0, 16'h0); end
    chk("R7", "running frame skipped", 256'(nRec), 256'(0));
    driveFrame(4, 0, 1); // R11 start pulse mid-frame
    checkFrame("R11", 4, 32'h0000_8000);
  endtask

  task automatic testIgnoreIdle();
    nRec = 0;
    driveFrame(5, 0, 0);
    chk("R7", "no writes while idle", 256'(nRec), 256'(0));
    chk("R7", "stays idle", 256'(busy), 256'(0));
  endtask

  task automatic testMisaligned();
    configure(0, 0, 0, 0, 0, 0, 32'h0000_3002, 1);
    pulseStart();
    chk("R9", "misaligned rejected", 256'({paramErr, busy, frameDone}), 256'(3'b101));
    configure(0, 0, 0, 0, 0, 0, 32'h0000_3000, 1);
    pulseStart();
    chk("R9", "valid start clears flags", 256'({paramErr, busy, frameDone}), 256'(3'b010));
    nRec = 0;
    driveFrame(6, 0, 0);
    checkFrame("R9", 6, 32'h0000_3000);
  endtask

  initial begin
    testReset();
    testWide();
    testNarrowLow();
    testWideSwap();
    testSkipAndRestart();
    testIgnoreIdle();
    testMisaligned();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule